// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This core encrypts one 128-bit block with a 128-bit key. It is built for minimum area. A single substitution circuit, the S-box, is time-multiplexed over every byte that needs one. The four key-schedule bytes of a round pass through it first, and the sixteen state bytes follow one per clock. After the last substitution, one further cycle applies the row rotation, the column mixing and the addition of the freshly expanded round key to the whole state at once. Round keys are derived on the fly, so no key storage beyond the current round key is needed. The S-box value is computed arithmetically, as an inverse in GF(2^8) followed by an affine map, so the core needs no table.

A block is started by pulsing `start` with the plaintext and key present on the inputs. The block takes ten rounds of 21 cycles each. At the end, `done` pulses for one cycle and the ciphertext is held on the output. The final round bypasses the column mixing.

Top module: `aes_ser_core`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the ciphertext is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: `done` rises exactly 210 clock edges after the edge that samples `start`: 10 rounds of 4 key substitutions, 16 state substitutions and 1 mixing cycle each.
- R3: `done` is a single-cycle pulse.
- R4: Once a block completes, `ciphertext` holds its value until the next accepted `start`, whatever the data inputs do.
- R5: A `start` pulse while a block is in progress is ignored, and the running block completes with its own result.
- R6: After reset, `done` is 0 and `ciphertext` is all zeros.
- R7: With key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, the ciphertext is 3925841d02dc09fbdc118597196a0b32. This exercises the round constants 01,02,04,08,10,20,40,80,1b,36 on a non-trivial key.
- R8: The substitution maps 00 to 63 and has no fixed point. With an all-zero key and plaintext the ciphertext is 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R9: Round 10 omits the column mixing. Every vector in R1, R7 and R8 depends on this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; ignored while a block is in progress |
| plaintext | input | 128 | Input block, byte 0 in bits 127:120 |
| cipher_key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| ciphertext | output | 128 | Result, valid from `done` until the next start |
| done | output | 1 | One-cycle completion pulse |

## Verification
Any fault in this core appears at the ports only 210 cycles after the start. A single bad byte in the state, the round key or the S-box output spreads over the whole block within two rounds, so a fault shows up as a completely wrong ciphertext rather than a single wrong byte. A fault in the step or round counters shows up instead as `done` arriving at the wrong cycle, or lasting longer than one cycle. Known-answer vectors on three different keys are therefore combined with an exact latency count and a hold check on the ciphertext.

// File: rtl/aes_ser_pkg.sv
package aes_ser_pkg;

  localparam int BLK_BYTES  = 16;
  localparam int WORD_BYTES = 4;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] s;
    p = 8'h00;
    s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ s;
      s = gf_xtime(s);
    end
    return p;
  endfunction

  // a^254 by square-and-multiply: product of a^2 .. a^128
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

endpackage

// File: rtl/aes_ser_sbox.sv
module aes_ser_sbox
  import aes_ser_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] inv;

  always_comb begin
    inv  = gf_inv(din);
    dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  end
endmodule

// File: rtl/aes_ser_round_mix.sv
module aes_ser_round_mix
  import aes_ser_pkg::*;
(
  input  logic [127:0] state_in,
  input  logic [127:0] rkey,
  input  logic         skip_mix,
  output logic [127:0] state_out
);
  logic [7:0] sb [BLK_BYTES];
  logic [7:0] sh [BLK_BYTES];

  // byte i: row i%4, column i/4; row r rotates left by r columns
  generate
    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_rows
      localparam int ROW = i % 4;
      localparam int COL = i / 4;
      localparam int SRC = 4 * ((COL + ROW) % 4) + ROW;
      assign sb[i] = state_in[8*(BLK_BYTES-1-i) +: 8];
      assign sh[i] = sb[SRC];
    end

    for (genvar c = 0; c < 4; c++) begin : g_cols
      logic [7:0] a0, a1, a2, a3;
      logic [7:0] m0, m1, m2, m3;
      logic [31:0] col_out;
      assign a0 = sh[4*c];
      assign a1 = sh[4*c+1];
      assign a2 = sh[4*c+2];
      assign a3 = sh[4*c+3];
      assign m0 = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
      assign m1 = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
      assign m2 = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
      assign m3 = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
      assign col_out = skip_mix ? {a0, a1, a2, a3} : {m0, m1, m2, m3};
      assign state_out[32*(3-c) +: 32] = col_out ^ rkey[32*(3-c) +: 32];
    end
  endgenerate
endmodule

// File: rtl/aes_ser_keyexp.sv
module aes_ser_keyexp (
  input  logic [127:0] key_in,
  input  logic [31:0]  sub_word,
  input  logic [7:0]   rcon,
  output logic [127:0] key_out
);
  logic [31:0] t, w0, w1, w2, w3;

  always_comb begin
    t  = sub_word ^ {rcon, 24'h000000};
    w0 = key_in[127:96] ^ t;
    w1 = key_in[95:64]  ^ w0;
    w2 = key_in[63:32]  ^ w1;
    w3 = key_in[31:0]   ^ w2;
    key_out = {w0, w1, w2, w3};
  end
endmodule

// File: rtl/aes_ser_ctrl.sv
module aes_ser_ctrl #(
  parameter int ROUNDS     = 10,
  parameter int KEY_SUBS   = 4,
  parameter int STATE_SUBS = 16,
  localparam int MIX_STEP  = KEY_SUBS + STATE_SUBS,
  localparam int SW        = $clog2(MIX_STEP + 1),
  localparam int RW        = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run,
  output logic [SW-1:0] step,
  output logic          key_phase,
  output logic          mix_cycle,
  output logic          last_round,
  output logic          load,
  output logic          done
);
  localparam logic [SW-1:0] STEP_MIX  = SW'(MIX_STEP);
  localparam logic [SW-1:0] STEP_KEYS = SW'(KEY_SUBS);
  localparam logic [RW-1:0] RND_LAST  = RW'(ROUNDS);

  logic          run_q, run_d;
  logic [SW-1:0] step_q, step_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic          done_q, done_d;

  assign run        = run_q;
  assign step       = step_q;
  assign done       = done_q;
  assign load       = start && !run_q;
  assign key_phase  = run_q && (step_q < STEP_KEYS);
  assign mix_cycle  = run_q && (step_q == STEP_MIX);
  assign last_round = (rnd_q == RND_LAST);

  always_comb begin
    run_d  = run_q;
    step_d = step_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    if (load) begin
      run_d  = 1'b1;
      step_d = '0;
      rnd_d  = RW'(1);
    end else if (run_q) begin
      if (step_q == STEP_MIX) begin
        step_d = '0;
        if (last_round) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          rnd_d = rnd_q + RW'(1);
        end
      end else begin
        step_d = step_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      step_q <= step_d;
      rnd_q  <= rnd_d;
      done_q <= done_d;
    end
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_last_mix: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run_q && last_round && step_q == STEP_MIX));
  a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q != STEP_MIX) |=> (run_q && step_q == $past(step_q) + SW'(1)
                                       && rnd_q == $past(rnd_q)));
  a_r2_round_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rnd_q >= RW'(1) && rnd_q <= RND_LAST));
endmodule

// File: rtl/aes_ser_core.sv
module aes_ser_core
  import aes_ser_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] plaintext,
  input  logic [127:0] cipher_key,
  output logic [127:0] ciphertext,
  output logic         done
);
  localparam int KEY_SUBS   = WORD_BYTES;
  localparam int STATE_SUBS = BLK_BYTES;
  localparam int SW         = $clog2(KEY_SUBS + STATE_SUBS + 1);

  logic          run, key_phase, mix_cycle, last_round, load;
  logic [SW-1:0] step;

  logic [127:0] state_q, state_d;
  logic [127:0] key_q, key_d;
  logic [31:0]  temp_q, temp_d;
  logic [7:0]   rcon_q, rcon_d;
  logic         state_en, key_en, temp_en, rcon_en;

  logic [7:0]   sub_in, sub_out;
  logic [127:0] mix_out, next_key;
  logic [1:0]   kbyte, krot;
  logic [3:0]   sbyte;

  aes_ser_ctrl #(
    .ROUNDS(ROUNDS), .KEY_SUBS(KEY_SUBS), .STATE_SUBS(STATE_SUBS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .run(run), .step(step), .key_phase(key_phase), .mix_cycle(mix_cycle),
    .last_round(last_round), .load(load), .done(done)
  );

  aes_ser_sbox u_sbox (.din(sub_in), .dout(sub_out));

  aes_ser_keyexp u_kexp (
    .key_in(key_q), .sub_word(temp_q), .rcon(rcon_q), .key_out(next_key)
  );

  aes_ser_round_mix u_mix (
    .state_in(state_q), .rkey(next_key), .skip_mix(last_round), .state_out(mix_out)
  );

  // key word 3 rotated left by one byte, then state bytes 0..15
  assign kbyte = 2'(step);
  assign krot  = kbyte + 2'd1;
  assign sbyte = 4'(step - SW'(KEY_SUBS));

  always_comb begin
    if (key_phase) sub_in = key_q[8*(3-int'(krot)) +: 8];
    else           sub_in = state_q[8*(BLK_BYTES-1-int'(sbyte)) +: 8];
  end

  always_comb begin
    state_d  = state_q;
    key_d    = key_q;
    temp_d   = temp_q;
    rcon_d   = rcon_q;
    state_en = 1'b0;
    key_en   = 1'b0;
    temp_en  = 1'b0;
    rcon_en  = 1'b0;
    if (load) begin
      state_d  = plaintext ^ cipher_key;
      key_d    = cipher_key;
      rcon_d   = 8'h01;
      state_en = 1'b1;
      key_en   = 1'b1;
      rcon_en  = 1'b1;
    end else if (mix_cycle) begin
      state_d  = mix_out;
      key_d    = next_key;
      rcon_d   = gf_xtime(rcon_q);
      state_en = 1'b1;
      key_en   = 1'b1;
      rcon_en  = 1'b1;
    end else if (key_phase) begin
      temp_d[8*(3-int'(kbyte)) +: 8] = sub_out;
      temp_en = 1'b1;
    end else if (run) begin
      state_d[8*(BLK_BYTES-1-int'(sbyte)) +: 8] = sub_out;
      state_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      key_q   <= '0;
      temp_q  <= '0;
      rcon_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (key_en)   key_q   <= key_d;
      if (temp_en)  temp_q  <= temp_d;
      if (rcon_en)  rcon_q  <= rcon_d;
    end
  end

  assign ciphertext = state_q;

  a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(ciphertext));
  a_r8_sbox_no_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mix_cycle) |-> (sub_out != sub_in));
  a_r9_rcon_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mix_cycle |-> $onehot0(rcon_q) || rcon_q == 8'h1b || rcon_q == 8'h36);
endmodule

// File: tb/aes_ser_core_tb_top.sv
module aes_ser_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plaintext = '0;
  logic [127:0] cipher_key = '0;
  logic [127:0] ciphertext;
  logic         done;

  typedef struct {
    logic [127:0] ct;
    int           t0;
    string        req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int seen = 0;
  bit pulse_chk = 1'b0;

  localparam int LATENCY = 210;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aes_ser_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
    .cipher_key(cipher_key), .ciphertext(ciphertext), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (pulse_chk) begin
      check(!done, "R3 done one cycle", 128'(done), 128'(0));
      pulse_chk <= 1'b0;
    end else if (done) begin
      if (q.size() == 0) begin
        check(1'b0, "R5 unexpected result", ciphertext, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(ciphertext === e.ct, e.req, ciphertext, e.ct);
        check(cyc - e.t0 == LATENCY, "R2 latency", 128'(cyc - e.t0), 128'(LATENCY));
      end
      pulse_chk <= 1'b1;
      seen <= seen + 1;
    end
  end

  task automatic issue(input logic [127:0] pt, input logic [127:0] k,
                       input logic [127:0] ct, input string req);
    @(negedge clk);
    plaintext  = pt;
    cipher_key = k;
    start      = 1'b1;
    q.push_back('{ct, cyc + 1, req});
    @(negedge clk);
    start      = 1'b0;
    plaintext  = '0;
    cipher_key = '0;
  endtask

  task automatic wait_done(input int target);
    while (seen < target) @(negedge clk);
  endtask

  task automatic hold_check(input logic [127:0] ct);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      plaintext  = {4{$urandom}};
      cipher_key = {4{$urandom}};
    end
    check(ciphertext === ct, "R4 ciphertext held", ciphertext, ct);
  endtask

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R6 reset done", 128'(done), 128'(0));
    check(ciphertext === '0, "R6 reset ciphertext", ciphertext, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(P1, K1, C1, "R1 R9 known answer");
    wait_done(1);
    hold_check(C1);

    // R5: a second start mid-block must not disturb the running block
    issue(P2, K2, C2, "R7 R5 R9 second key");
    repeat (50) @(negedge clk);
    plaintext = '0; cipher_key = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(2);
    hold_check(C2);

    issue('0, '0, C0, "R8 R9 all-zero block");
    wait_done(3);
    hold_check(C0);

    issue(P1, K1, C1, "R1 repeat after others");
    wait_done(4);
    hold_check(C1);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R5 no extra results", 128'(q.size()), 128'(0));
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 128'(cyc), '0);
    finish_run();
  end
endmodule